// File: doc/BRIEF.md
# Update-Form Operand Legality Checker

This block inspects one 32-bit instruction word per cycle and decides, without any state, whether it belongs to a small family of memory-access and control forms whose operand fields are constrained. The family covers loads and stores that write the computed address back to the base register, floating-point and quadword register-pair accesses, the load-multiple-word form, the branch through the count register and the move to a special register. For each recognised word the block also reports whether the operand fields break the rule that applies to that form.

Bit 0 of the instruction word is its most significant bit (port bit 31). The primary opcode sits in bits 0..5, the target/source register field in bits 6..10, the base register field (RA) in bits 11..15, the index field in bits 16..20, and the 10-bit extended opcode of primary opcode 31 in bits 21..30. Doubleword-displacement forms carry a 2-bit sub-opcode in bits 30..31. The outputs are purely combinational and valid in the same cycle as the input word. A decode stage can use them to raise an illegal-instruction exception before issue.

Top module: `upd_form_checker`

## Requirements
- R1: Integer loads with update get kind 1. These are primary opcodes 35, 41, 43 and 33, primary 58 with sub-opcode 1, and primary 31 with extended codes 119, 311, 375, 55, 373 and 53. Such a word is illegal when RA is 0 or RA equals the target field.
- R2: Integer stores with update get kind 2 and are illegal only when RA is 0. These are primary opcodes 39, 45 and 37, primary 62 with sub-opcode 1, and primary 31 with extended codes 247, 439, 183 and 181.
- R3: Floating loads and stores with update get kind 3 and are illegal only when RA is 0. These are primary opcodes 49, 51, 53 and 55, and primary 31 with extended codes 567, 631, 695 and 759.
- R4: Register-pair accesses get kind 4 and are illegal exactly when the pair register field (bits 6..10) is odd. These are primary 57 with sub-opcode 0, primary 61 with sub-opcode 0, primary 31 with extended codes 791 and 919, and primary 62 with sub-opcode 2.
- R5: The quadword load (primary 56) gets kind 5. It is illegal when its pair register field is odd or equals RA.
- R6: Load-multiple-word (primary 46) gets kind 6. It is illegal when RA is 0 or when RA is greater than or equal to the target field.
- R7: Branch through the count register (primary 19, extended 528) gets kind 7. It is illegal exactly when instruction bit 8 (BO bit 2, port bit 23) is 0.
- R8: Move-to-special-register (primary 31, extended 467) gets kind 8. The SPR number is formed as bits 16..20 (high half) concatenated with bits 11..15 (low half). The word is legal only for the SPR numbers 1, 8, 9, 256, 512, 896 and 898.
- R9: Any other word gives recognised 0, illegal 0 and kind 0. This includes primary 58 and 62 with sub-opcode 0, and primary 57 and 61 with nonzero sub-opcodes.
- R10: The illegal flag is never high unless the recognised flag is high, and the recognised flag is high exactly when the kind is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word, port bit 31 is instruction bit 0 |
| known_o | output | 1 | Word belongs to one of the checked forms |
| illegal_o | output | 1 | Operand fields violate the rule of that form |
| kind_o | output | 4 | Form class code 0..8 as listed in the requirements |

## Verification
The block has a single fixed configuration: a 32-bit word and a fixed set of opcodes. The bench therefore builds it as it stands and spends its effort on operand coverage. Random words are generated from every recognised opcode template. The base field is biased toward 0 and toward the target field, and pair fields are spread across odd and even values. Every SPR in the legal set is exercised along with neighbouring numbers. Sub-opcode variants that must stay unrecognised are included.

// File: rtl/upd_form_checker.sv
module upd_form_checker (
  input  logic [31:0] insn_i,
  output logic        known_o,
  output logic        illegal_o,
  output logic [3:0]  kind_o
);

  localparam logic [3:0] K_NONE  = 4'd0;
  localparam logic [3:0] K_LDU   = 4'd1;
  localparam logic [3:0] K_STU   = 4'd2;
  localparam logic [3:0] K_FPU   = 4'd3;
  localparam logic [3:0] K_PAIR  = 4'd4;
  localparam logic [3:0] K_QLD   = 4'd5;
  localparam logic [3:0] K_LMW   = 4'd6;
  localparam logic [3:0] K_BCTR  = 4'd7;
  localparam logic [3:0] K_MTSPR = 4'd8;

  logic [5:0] op;
  logic [4:0] rt, ra, rb;
  logic [9:0] xo, spr;
  logic [1:0] sub;
  logic       ra_zero, ra_eq_rt, rt_odd, spr_ok;

  assign op  = insn_i[31:26];
  assign rt  = insn_i[25:21];
  assign ra  = insn_i[20:16];
  assign rb  = insn_i[15:11];
  assign xo  = insn_i[10:1];
  assign sub = insn_i[1:0];
  assign spr = {rb, ra};

  assign ra_zero  = (ra == 5'd0);
  assign ra_eq_rt = (ra == rt);
  assign rt_odd   = rt[0];

  always_comb begin
    case (spr)
      10'd1, 10'd8, 10'd9, 10'd256, 10'd512, 10'd896, 10'd898: spr_ok = 1'b1;
      default: spr_ok = 1'b0;
    endcase
  end

  always_comb begin
    kind_o = K_NONE;
    case (op)
      6'd33, 6'd35, 6'd41, 6'd43: kind_o = K_LDU;
      6'd37, 6'd39, 6'd45:        kind_o = K_STU;
      6'd49, 6'd51, 6'd53, 6'd55: kind_o = K_FPU;
      6'd56:                      kind_o = K_QLD;
      6'd46:                      kind_o = K_LMW;
      6'd58: if (sub == 2'd1) kind_o = K_LDU;
      6'd62: begin
        if (sub == 2'd1)      kind_o = K_STU;
        else if (sub == 2'd2) kind_o = K_PAIR;
      end
      6'd57, 6'd61: if (sub == 2'd0) kind_o = K_PAIR;
      6'd19: if (xo == 10'd528) kind_o = K_BCTR;
      6'd31: begin
        case (xo)
          10'd119, 10'd311, 10'd375, 10'd55, 10'd373, 10'd53: kind_o = K_LDU;
          10'd247, 10'd439, 10'd183, 10'd181:                 kind_o = K_STU;
          10'd567, 10'd631, 10'd695, 10'd759:                 kind_o = K_FPU;
          10'd791, 10'd919:                                   kind_o = K_PAIR;
          10'd467:                                            kind_o = K_MTSPR;
          default:                                            kind_o = K_NONE;
        endcase
      end
      default: kind_o = K_NONE;
    endcase
  end

  always_comb begin
    case (kind_o)
      K_LDU:   illegal_o = ra_zero | ra_eq_rt;
      K_STU:   illegal_o = ra_zero;
      K_FPU:   illegal_o = ra_zero;
      K_PAIR:  illegal_o = rt_odd;
      K_QLD:   illegal_o = rt_odd | ra_eq_rt;
      K_LMW:   illegal_o = ra_zero | (ra >= rt);
      K_BCTR:  illegal_o = ~insn_i[23];
      K_MTSPR: illegal_o = ~spr_ok;
      default: illegal_o = 1'b0;
    endcase
  end

  assign known_o = (kind_o != K_NONE);

endmodule

// File: rtl/upd_form_checker_chk.sv
module upd_form_checker_chk (
  input logic [31:0] insn_i,
  input logic        known_o,
  input logic        illegal_o,
  input logic [3:0]  kind_o
);

  always_comb begin
    if (illegal_o)
      assert_illegal_needs_known_R10: assert (known_o);
    assert_known_matches_kind_R10: assert (known_o == (kind_o != 4'd0));
    if (kind_o == 4'd7)
      assert_bctr_bo2_R7: assert (illegal_o == !insn_i[23]);
    if (kind_o == 4'd2)
      assert_store_base_R2: assert (illegal_o == (insn_i[20:16] == 5'd0));
    if (kind_o == 4'd1 && insn_i[20:16] == insn_i[25:21])
      assert_load_alias_R1: assert (illegal_o);
    if (kind_o == 4'd6 && insn_i[20:16] == 5'd0)
      assert_lmw_base_R6: assert (illegal_o);
    if (kind_o == 4'd4)
      assert_pair_parity_R4: assert (illegal_o == insn_i[21]);
    if (insn_i[31:26] == 6'd0)
      assert_opcode_zero_R9: assert (!known_o && !illegal_o);
  end

endmodule

bind upd_form_checker upd_form_checker_chk chk_i (
  .insn_i(insn_i),
  .known_o(known_o),
  .illegal_o(illegal_o),
  .kind_o(kind_o)
);

// File: tb/upd_form_checker_tb_top.sv
module upd_form_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = 32'd0;
  logic        known, illegal;
  logic [3:0]  kind;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  upd_form_checker dut_i (
    .insn_i(insn),
    .known_o(known),
    .illegal_o(illegal),
    .kind_o(kind)
  );

  function automatic logic [31:0] mk_d(int op, int rt, int ra, int low16);
    return (32'(op) << 26) | (32'(rt & 31) << 21) | (32'(ra & 31) << 16) | 32'(low16 & 16'hffff);
  endfunction

  function automatic logic [31:0] mk_x(int rt, int ra, int rb, int xo);
    return (32'd31 << 26) | (32'(rt & 31) << 21) | (32'(ra & 31) << 16) | (32'(rb & 31) << 11) | (32'(xo & 1023) << 1);
  endfunction

  function automatic logic [31:0] mk_ds(int op, int rt, int ra, int sub);
    return (32'(op) << 26) | (32'(rt & 31) << 21) | (32'(ra & 31) << 16) | 32'h0000_0040 | 32'(sub & 3);
  endfunction

  // Behavioural reference: kind, illegal flag and requirement tag
  task automatic ref_model(input logic [31:0] w, output int k, output bit ill, output string tag);
    int op, rt, ra, rb, xo, sub, spr;
    op  = int'(w / 32'h0400_0000);
    rt  = int'(w / 32'h0020_0000) % 32;
    ra  = int'(w / 32'h0001_0000) % 32;
    rb  = int'(w / 32'h0000_0800) % 32;
    xo  = int'(w / 2) % 1024;
    sub = int'(w % 4);
    spr = rb * 32 + ra;
    k = 0; ill = 0; tag = "R9";
    if (op inside {33, 35, 41, 43} || (op == 58 && sub == 1) ||
        (op == 31 && xo inside {119, 311, 375, 55, 373, 53})) begin
      k = 1; ill = (ra == 0) || (ra == rt); tag = "R1";
    end else if (op inside {37, 39, 45} || (op == 62 && sub == 1) ||
                 (op == 31 && xo inside {247, 439, 183, 181})) begin
      k = 2; ill = (ra == 0); tag = "R2";
    end else if (op inside {49, 51, 53, 55} || (op == 31 && xo inside {567, 631, 695, 759})) begin
      k = 3; ill = (ra == 0); tag = "R3";
    end else if ((op inside {57, 61} && sub == 0) || (op == 62 && sub == 2) ||
                 (op == 31 && xo inside {791, 919})) begin
      k = 4; ill = (rt % 2) == 1; tag = "R4";
    end else if (op == 56) begin
      k = 5; ill = ((rt % 2) == 1) || (rt == ra); tag = "R5";
    end else if (op == 46) begin
      k = 6; ill = (ra == 0) || (ra >= rt); tag = "R6";
    end else if (op == 19 && xo == 528) begin
      k = 7; ill = (((rt / 4) % 2) == 0); tag = "R7";
    end else if (op == 31 && xo == 467) begin
      k = 8; ill = !(spr inside {1, 8, 9, 256, 512, 896, 898}); tag = "R8";
    end
  endtask

  task automatic check_now(input string why);
    int  ek;
    bit  eil;
    string tag;
    ref_model(insn, ek, eil, tag);
    total++;
    // R10: known tracks nonzero kind and illegal implies known
    if (kind !== 4'(ek) || illegal !== eil || known !== (ek != 0)) begin
      bad++;
      $display("FAIL %s (%s) insn=%h actual known=%b ill=%b kind=%0d expected known=%b ill=%b kind=%0d",
               tag, why, insn, known, illegal, kind, (ek != 0), eil, ek);
    end
  endtask

  task automatic apply(input logic [31:0] w, input string why);
    @(posedge clk);
    insn <= w;
    @(negedge clk);
    check_now(why);
  endtask

  int d_ops[] = '{33, 35, 41, 43, 37, 39, 45, 49, 51, 53, 55, 56, 46};
  int x_ops[] = '{119, 311, 375, 55, 373, 53, 247, 439, 183, 181, 567, 631, 695, 759, 791, 919};
  int sprs[]  = '{0, 1, 2, 8, 9, 10, 255, 256, 257, 511, 512, 513, 895, 896, 897, 898, 899, 1023};

  function automatic int pick_ra(int rt);
    int r;
    r = $urandom_range(0, 3);
    if (r == 0) return 0;
    if (r == 1) return rt;
    return $urandom_range(0, 31);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_now("reset state, opcode 0 R9");
    rst = 1'b0;

    apply(mk_d(35, 4, 0, 8), "R1 lbzu base zero");
    apply(mk_d(41, 6, 6, 8), "R1 lhzu base equals target");
    apply(mk_d(43, 6, 7, 8), "R1 lhau legal");
    apply(mk_ds(58, 3, 3, 1), "R1 ldu alias");
    apply(mk_ds(58, 3, 4, 0), "R9 plain ld unrecognised");
    apply(mk_x(9, 9, 2, 373), "R1 lwaux alias");
    apply(mk_d(39, 0, 0, 4), "R2 stbu base zero");
    apply(mk_d(45, 5, 5, 4), "R2 sthu alias is legal");
    apply(mk_ds(62, 1, 0, 1), "R2 stdu base zero");
    apply(mk_ds(62, 1, 2, 0), "R9 plain std unrecognised");
    apply(mk_x(2, 0, 3, 695), "R3 stfsux base zero");
    apply(mk_d(51, 7, 7, 0), "R3 lfdu alias legal");
    apply(mk_ds(57, 3, 1, 0), "R4 odd pair");
    apply(mk_ds(61, 4, 0, 0), "R4 even pair legal");
    apply(mk_ds(57, 4, 1, 2), "R9 pair opcode bad sub");
    apply(mk_ds(62, 5, 1, 2), "R4 stq odd");
    apply(mk_x(2, 1, 1, 919), "R4 stfdpx even");
    apply(mk_d(56, 4, 4, 0), "R5 lq pair equals base");
    apply(mk_d(56, 5, 2, 0), "R5 lq odd");
    apply(mk_d(56, 4, 2, 0), "R5 lq legal");
    apply(mk_d(46, 10, 31, 0), "R6 lmw base at top");
    apply(mk_d(46, 10, 10, 0), "R6 lmw base equals first");
    apply(mk_d(46, 10, 9, 0), "R6 lmw base below range");
    apply(mk_d(46, 10, 0, 0), "R6 lmw base zero");
    apply((32'd19 << 26) | (32'd20 << 21) | (32'd528 << 1), "R7 bcctr BO2 set");
    apply((32'd19 << 26) | (32'd16 << 21) | (32'd528 << 1), "R7 bcctr BO2 clear");
    apply((32'd19 << 26) | (32'd16 << 21) | (32'd16 << 1), "R9 other branch form");
    foreach (sprs[i]) apply(mk_x(3, sprs[i] % 32, sprs[i] / 32, 467), "R8 spr sweep");
    apply(32'hffff_ffff, "R9 all ones");

    for (int n = 0; n < 3000; n++) begin
      int sel, rt, ra;
      logic [31:0] w;
      sel = $urandom_range(0, 7);
      rt  = $urandom_range(0, 31);
      ra  = pick_ra(rt);
      case (sel)
        0, 1: w = mk_d(d_ops[$urandom_range(0, d_ops.size() - 1)], rt, ra, $urandom);
        2, 3: w = mk_x(rt, ra, $urandom_range(0, 31), x_ops[$urandom_range(0, x_ops.size() - 1)]);
        4:    w = mk_ds(56 + $urandom_range(0, 6), rt, ra, $urandom_range(0, 3));
        5:    w = (32'd19 << 26) | (32'(rt) << 21) | (32'(ra) << 16) | (32'd528 << 1) | 32'($urandom_range(0, 1));
        6:    w = mk_x(rt, $urandom_range(0, 31), $urandom_range(0, 31), 467);
        default: w = $urandom;
      endcase
      apply(w, "random mix");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule